// File: doc/BRIEF.md
# Storage Controller Core Register and Enable Handler

This block holds the core control registers of a storage controller that talks to a host through paired submission and completion queues. A 32-bit register bus writes and reads the configuration word, the status word, the admin queue attributes, the two 64-bit admin queue base addresses, and the interrupt mask set and clear locations. Register reads are combinational on the address, so a read returns the value the register holds in the current cycle.

Each configuration write is compared with the configuration value stored before it. A rising enable bit sends a one-cycle start request to the start-up logic, and the controller becomes ready only after that logic answers. If the answer is a failure, the fatal status bit is set instead. A falling enable bit performs a controller reset: it clears the configuration and status words, pulses a reset request, and cancels any start still waiting for its answer. The admin queue setup is kept. A shutdown notification that rises from zero reports shutdown complete and leaves the configuration unchanged. A reset or a shutdown also empties the interrupt mask and the pending interrupt state.

Top module: `qcr_core_regs`

## Requirements
- R1: A write to the configuration word at 0x14 stores the data ANDed with 0x00FFFFF1, and a read returns the stored value. Fields: enable bit 0, command set 6:4, page size 10:7, arbitration 13:11, shutdown notification 15:14, submission entry size 19:16, completion entry size 23:20.
- R2: A write to the admin queue attributes at 0x24 is masked with 0x0FFF0FFF. The admin submission base low word at 0x28 and the admin completion base low word at 0x30 have their low 12 bits forced to zero. The high words at 0x2C and 0x34 store all 32 bits.
- R3: When a configuration write changes the enable bit from 0 to 1, start_req_o is high for exactly the one cycle after the write. A write that leaves the enable bit at 1 produces no start request.
- R4: The status word at 0x1C has ready at bit 0, fatal at bit 1 and shutdown status at bits 3:2. Ready stays 0 until a start response arrives. A response with start_rsp_ok_i=1 sets ready, and a response with start_rsp_ok_i=0 sets fatal. A response that arrives while no start is pending has no effect.
- R5: When a configuration write changes the enable bit from 1 to 0, the configuration and status words read 0 afterwards. ctrl_reset_o pulses for one cycle and the admin registers keep their values. A start request still waiting for its response is cancelled, so a later response changes nothing.
- R6: When the shutdown notification field changes from zero to nonzero, status bits 3:2 become 2'b10 and the configuration word keeps the value written. When the field changes from nonzero to zero, bits 3:2 clear. A change from one nonzero value to another leaves the status unchanged.
- R7: If a single write both clears the enable bit and raises the shutdown field, the configuration word reads 0 and the status word reads 0x8.
- R8: Writing 0x0C sets the written mask bits. Writing 0x10 clears the written mask bits. Both addresses read the mask. irq_set_i sets pending bits and irq_clr_i clears them. irq_o is high when any pending bit is unmasked.
- R9: A controller reset or a shutdown rise clears the interrupt mask and all pending bits, so irq_o is low in the cycle after the write.
- R10: Writes to the status word are ignored, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| start_req_o | output | 1 | One-cycle controller start request |
| start_rsp_valid_i | input | 1 | Start response strobe |
| start_rsp_ok_i | input | 1 | Start response result, 1 = success |
| ctrl_reset_o | output | 1 | One-cycle controller reset request |
| irq_set_i | input | NUM_VEC | Per-vector pending set |
| irq_clr_i | input | NUM_VEC | Per-vector pending clear |
| irq_o | output | 1 | Interrupt output |

## Verification
Every register update happens at the clock edge that takes the write or strobe. Stored values are readable as soon as that edge has passed. start_req_o and ctrl_reset_o are registered, so each is high for the one cycle after the write edge. The ready and fatal bits follow the edge at which the response is taken, and irq_o follows the edge that updates the mask or the pending bits. The bench applies each stimulus at a falling edge and holds it across one rising edge. It samples at the next falling edge, and it samples once more a cycle later to confirm that each pulse has ended.

// File: rtl/qcr_pkg.sv
package qcr_pkg;
  typedef struct packed {
    logic [7:0] rsvd_hi;
    logic [3:0] iocqes;
    logic [3:0] iosqes;
    logic [1:0] shn;
    logic [2:0] ams;
    logic [3:0] mps;
    logic [2:0] css;
    logic [2:0] rsvd_lo;
    logic       en;
  } cc_t;

  localparam logic [31:0] CC_WMASK      = 32'h00FF_FFF1;
  localparam logic [31:0] AQA_WMASK     = 32'h0FFF_0FFF;
  localparam logic [31:0] BASE_LO_WMASK = 32'hFFFF_F000;
  localparam logic [1:0]  SHST_DONE     = 2'b10;

  localparam logic [7:0] OFS_IMSET  = 8'h0C;
  localparam logic [7:0] OFS_IMCLR  = 8'h10;
  localparam logic [7:0] OFS_CC     = 8'h14;
  localparam logic [7:0] OFS_CSTS   = 8'h1C;
  localparam logic [7:0] OFS_AQA    = 8'h24;
  localparam logic [7:0] OFS_ASQ_LO = 8'h28;
  localparam logic [7:0] OFS_ASQ_HI = 8'h2C;
  localparam logic [7:0] OFS_ACQ_LO = 8'h30;
  localparam logic [7:0] OFS_ACQ_HI = 8'h34;
endpackage

// File: rtl/qcr_admin_regs.sv
module qcr_admin_regs
  import qcr_pkg::*;
#(
  parameter int unsigned NUM_BASE = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                aqa_we_i,
  input  logic [NUM_BASE-1:0] lo_we_i,
  input  logic [NUM_BASE-1:0] hi_we_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         aqa_o,
  output logic [NUM_BASE-1:0][63:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       aqa_o <= '0;
    else if (aqa_we_i) aqa_o <= wdata_i & AQA_WMASK;
  end

  for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
    logic [31:0] lo_q, hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (lo_we_i[g]) lo_q <= wdata_i & BASE_LO_WMASK;
        if (hi_we_i[g]) hi_q <= wdata_i;
      end
    end
    assign base_o[g] = {hi_q, lo_q};

    // R2
    base_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lo_we_i[g] |=> (lo_q[11:0] == 12'h000));
  end
endmodule

// File: rtl/qcr_irq_ctrl.sv
module qcr_irq_ctrl #(
  parameter int unsigned NUM_VEC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_we_i,
  input  logic               clr_we_i,
  input  logic [NUM_VEC-1:0] wdata_i,
  input  logic               clear_all_i,
  input  logic [NUM_VEC-1:0] irq_set_i,
  input  logic [NUM_VEC-1:0] irq_clr_i,
  output logic [NUM_VEC-1:0] mask_o,
  output logic               irq_o
);
  logic [NUM_VEC-1:0] mask_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      pend_q <= '0;
    end else if (clear_all_i) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (set_we_i)      mask_q <= mask_q | wdata_i;
      else if (clr_we_i) mask_q <= mask_q & ~wdata_i;
      pend_q <= (pend_q | irq_set_i) & ~irq_clr_i;
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = |(pend_q & ~mask_q);

  // R9
  clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_all_i |=> (mask_q == '0 && !irq_o));
  // R8
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_q != '0));
endmodule

// File: rtl/qcr_enable_ctl.sv
module qcr_enable_ctl
  import qcr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cc_we_i,
  input  logic [31:0] wdata_i,
  input  logic        start_rsp_valid_i,
  input  logic        start_rsp_ok_i,
  output logic [31:0] cc_o,
  output logic [31:0] csts_o,
  output logic        start_req_o,
  output logic        ctrl_reset_o,
  output logic        clear_all_o
);
  cc_t        cc_q, cc_new;
  logic       rdy_q, cfs_q, pend_q, req_q, rst_q;
  logic [1:0] shst_q;
  logic       en_rise, en_fall, shn_rise, shn_fall, rsp_take;

  assign cc_new   = cc_t'(wdata_i & CC_WMASK);
  assign en_rise  = cc_we_i &&  cc_new.en && !cc_q.en;
  assign en_fall  = cc_we_i && !cc_new.en &&  cc_q.en;
  assign shn_rise = cc_we_i && (cc_new.shn != 2'b00) && (cc_q.shn == 2'b00);
  assign shn_fall = cc_we_i && (cc_new.shn == 2'b00) && (cc_q.shn != 2'b00);
  // a disable on the same edge cancels the response
  assign rsp_take = start_rsp_valid_i && pend_q && !en_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q   <= '0;
      rdy_q  <= 1'b0;
      cfs_q  <= 1'b0;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
      rst_q  <= 1'b0;
      shst_q <= 2'b00;
    end else begin
      req_q <= en_rise;
      rst_q <= en_fall;
      if (cc_we_i) cc_q <= en_fall ? cc_t'('0) : cc_new;

      if (en_fall)       pend_q <= 1'b0;
      else if (en_rise)  pend_q <= 1'b1;
      else if (rsp_take) pend_q <= 1'b0;

      if (en_fall) begin
        rdy_q <= 1'b0;
        cfs_q <= 1'b0;
      end else if (rsp_take) begin
        rdy_q <= start_rsp_ok_i;
        cfs_q <= !start_rsp_ok_i;
      end

      if (shn_rise)                 shst_q <= SHST_DONE;
      else if (en_fall || shn_fall) shst_q <= 2'b00;
    end
  end

  assign cc_o         = cc_q;
  assign csts_o       = {28'd0, shst_q, cfs_q, rdy_q};
  assign start_req_o  = req_q;
  assign ctrl_reset_o = rst_q;
  assign clear_all_o  = en_fall || shn_rise;

  // R3
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_o |=> !start_req_o);
  // R4
  rdy_cfs_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rdy_q && cfs_q));
  // R4
  rdy_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_q |-> cc_q.en);
  // R5
  disable_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_fall |=> (cc_q == '0 && !rdy_q && !pend_q && ctrl_reset_o));
  // R6
  shn_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shn_rise |=> (shst_q == SHST_DONE));
endmodule

// File: rtl/qcr_core_regs.sv
module qcr_core_regs
  import qcr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_VEC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               start_req_o,
  input  logic               start_rsp_valid_i,
  input  logic               start_rsp_ok_i,
  output logic               ctrl_reset_o,
  input  logic [NUM_VEC-1:0] irq_set_i,
  input  logic [NUM_VEC-1:0] irq_clr_i,
  output logic               irq_o
);
  localparam int unsigned NUM_BASE = 2;

  logic [31:0]                cc_w, csts_w, aqa_w;
  logic [NUM_BASE-1:0][63:0]  base_w;
  logic [NUM_VEC-1:0]         mask_w;
  logic                       clear_all_w;
  logic                       sel_cc, sel_aqa, sel_imset, sel_imclr;
  logic [NUM_BASE-1:0]        sel_lo, sel_hi;

  assign sel_cc    = bus_we_i && (bus_addr_i == ADDR_W'(OFS_CC));
  assign sel_aqa   = bus_we_i && (bus_addr_i == ADDR_W'(OFS_AQA));
  assign sel_imset = bus_we_i && (bus_addr_i == ADDR_W'(OFS_IMSET));
  assign sel_imclr = bus_we_i && (bus_addr_i == ADDR_W'(OFS_IMCLR));
  assign sel_lo    = {bus_we_i && (bus_addr_i == ADDR_W'(OFS_ACQ_LO)),
                      bus_we_i && (bus_addr_i == ADDR_W'(OFS_ASQ_LO))};
  assign sel_hi    = {bus_we_i && (bus_addr_i == ADDR_W'(OFS_ACQ_HI)),
                      bus_we_i && (bus_addr_i == ADDR_W'(OFS_ASQ_HI))};

  qcr_enable_ctl u_enable (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .cc_we_i           (sel_cc),
    .wdata_i           (bus_wdata_i),
    .start_rsp_valid_i (start_rsp_valid_i),
    .start_rsp_ok_i    (start_rsp_ok_i),
    .cc_o              (cc_w),
    .csts_o            (csts_w),
    .start_req_o       (start_req_o),
    .ctrl_reset_o      (ctrl_reset_o),
    .clear_all_o       (clear_all_w)
  );

  qcr_admin_regs #(.NUM_BASE(NUM_BASE)) u_admin (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .aqa_we_i (sel_aqa),
    .lo_we_i  (sel_lo),
    .hi_we_i  (sel_hi),
    .wdata_i  (bus_wdata_i),
    .aqa_o    (aqa_w),
    .base_o   (base_w)
  );

  qcr_irq_ctrl #(.NUM_VEC(NUM_VEC)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_we_i    (sel_imset),
    .clr_we_i    (sel_imclr),
    .wdata_i     (bus_wdata_i[NUM_VEC-1:0]),
    .clear_all_i (clear_all_w),
    .irq_set_i   (irq_set_i),
    .irq_clr_i   (irq_clr_i),
    .mask_o      (mask_w),
    .irq_o       (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(OFS_IMSET) || bus_addr_i == ADDR_W'(OFS_IMCLR))
      bus_rdata_o = 32'(mask_w);
    else if (bus_addr_i == ADDR_W'(OFS_CC))     bus_rdata_o = cc_w;
    else if (bus_addr_i == ADDR_W'(OFS_CSTS))   bus_rdata_o = csts_w;
    else if (bus_addr_i == ADDR_W'(OFS_AQA))    bus_rdata_o = aqa_w;
    else if (bus_addr_i == ADDR_W'(OFS_ASQ_LO)) bus_rdata_o = base_w[0][31:0];
    else if (bus_addr_i == ADDR_W'(OFS_ASQ_HI)) bus_rdata_o = base_w[0][63:32];
    else if (bus_addr_i == ADDR_W'(OFS_ACQ_LO)) bus_rdata_o = base_w[1][31:0];
    else if (bus_addr_i == ADDR_W'(OFS_ACQ_HI)) bus_rdata_o = base_w[1][63:32];
  end

  // R5
  reset_start_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_req_o && ctrl_reset_o));
endmodule

// File: tb/qcr_core_regs_bench.sv
module qcr_core_regs_bench;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned NUM_VEC = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               we = 1'b0;
  logic [ADDR_W-1:0]  addr = '0;
  logic [31:0]        wdata = '0;
  logic [31:0]        rdata;
  logic               start_req, rsp_valid = 1'b0, rsp_ok = 1'b0, ctrl_reset;
  logic [NUM_VEC-1:0] irq_set = '0, irq_clr = '0;
  logic               irq;
  int                 n_chk = 0, n_bad = 0;
  bit                 done = 1'b0;

  always #4 clk = ~clk;

  qcr_core_regs #(.ADDR_W(ADDR_W), .NUM_VEC(NUM_VEC)) u_qcr_core_regs (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .start_req_o(start_req),
    .start_rsp_valid_i(rsp_valid), .start_rsp_ok_i(rsp_ok),
    .ctrl_reset_o(ctrl_reset), .irq_set_i(irq_set), .irq_clr_i(irq_clr),
    .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic respond(logic ok);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_ok = ok;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic pulse_irq(logic [NUM_VEC-1:0] s, logic [NUM_VEC-1:0] c);
    @(negedge clk);
    irq_set = s; irq_clr = c;
    @(negedge clk);
    irq_set = '0; irq_clr = '0;
  endtask

  task automatic t_reset;
    rd_chk("R1 cc after reset", 8'h14, 32'h0);
    rd_chk("R4 csts after reset", 8'h1C, 32'h0);
    rd_chk("R10 unmapped read", 8'h40, 32'h0);
    check("R8 irq after reset", 32'(irq), 32'h0);
    check("R3 no start after reset", 32'(start_req), 32'h0);
  endtask

  task automatic t_cc_mask;
    wr(8'h14, 32'hFFFF_3FFE);
    rd_chk("R1 cc write mask", 8'h14, 32'h00FF_3FF0);
    check("R3 no start without enable", 32'(start_req), 32'h0);
    wr(8'h14, 32'h0);
    rd_chk("R1 cc cleared by write", 8'h14, 32'h0);
  endtask

  task automatic t_admin;
    wr(8'h24, 32'hFFFF_FFFF);
    rd_chk("R2 aqa mask", 8'h24, 32'h0FFF_0FFF);
    wr(8'h28, 32'h1234_5678);
    rd_chk("R2 asq lo mask", 8'h28, 32'h1234_5000);
    wr(8'h2C, 32'hDEAD_BEEF);
    rd_chk("R2 asq hi", 8'h2C, 32'hDEAD_BEEF);
    wr(8'h30, 32'hFFFF_FFFF);
    rd_chk("R2 acq lo mask", 8'h30, 32'hFFFF_F000);
    wr(8'h34, 32'h0000_00A5);
    rd_chk("R2 acq hi", 8'h34, 32'h0000_00A5);
  endtask

  task automatic t_start_ok;
    wr(8'h14, 32'h0046_0001);
    check("R3 start pulse", 32'(start_req), 32'h1);
    rd_chk("R4 not ready before response", 8'h1C, 32'h0);
    @(negedge clk);
    check("R3 start pulse ends", 32'(start_req), 32'h0);
    repeat (3) @(negedge clk);
    rd_chk("R4 still waiting", 8'h1C, 32'h0);
    wr(8'h14, 32'h0046_0001);
    check("R3 no start when enable stays 1", 32'(start_req), 32'h0);
    respond(1'b1);
    rd_chk("R4 ready after ok", 8'h1C, 32'h1);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd_chk("R10 csts write ignored", 8'h1C, 32'h1);
  endtask

  task automatic t_disable;
    wr(8'h14, 32'h0046_0000);
    check("R5 reset pulse", 32'(ctrl_reset), 32'h1);
    rd_chk("R5 cc cleared", 8'h14, 32'h0);
    rd_chk("R5 csts cleared", 8'h1C, 32'h0);
    rd_chk("R5 aqa kept", 8'h24, 32'h0FFF_0FFF);
    rd_chk("R5 asq hi kept", 8'h2C, 32'hDEAD_BEEF);
    rd_chk("R5 acq lo kept", 8'h30, 32'hFFFF_F000);
    @(negedge clk);
    check("R5 reset pulse ends", 32'(ctrl_reset), 32'h0);
  endtask

  task automatic t_start_fail;
    wr(8'h14, 32'h1);
    respond(1'b0);
    rd_chk("R4 fatal on failed start", 8'h1C, 32'h2);
    respond(1'b1);
    rd_chk("R4 response without pending ignored", 8'h1C, 32'h2);
    wr(8'h14, 32'h0);
    rd_chk("R5 fatal cleared by reset", 8'h1C, 32'h0);
  endtask

  task automatic t_cancel;
    wr(8'h14, 32'h1);
    wr(8'h14, 32'h0);
    respond(1'b1);
    rd_chk("R5 cancelled start stays idle", 8'h1C, 32'h0);
  endtask

  task automatic t_shutdown;
    wr(8'h14, 32'h0000_4001);
    rd_chk("R6 shutdown complete", 8'h1C, 32'h8);
    rd_chk("R6 cc kept on shutdown", 8'h14, 32'h0000_4001);
    respond(1'b1);
    rd_chk("R6 ready with shutdown", 8'h1C, 32'h9);
    wr(8'h14, 32'h0000_8001);
    rd_chk("R6 nonzero to nonzero no change", 8'h1C, 32'h9);
    wr(8'h14, 32'h0000_0001);
    rd_chk("R6 shutdown status cleared", 8'h1C, 32'h1);
  endtask

  task automatic t_combined;
    wr(8'h14, 32'h0000_4000);
    rd_chk("R7 cc zero", 8'h14, 32'h0);
    rd_chk("R7 csts shutdown only", 8'h1C, 32'h8);
    check("R7 reset pulse", 32'(ctrl_reset), 32'h1);
  endtask

  task automatic t_irq;
    wr(8'h0C, 32'h5);
    rd_chk("R8 mask set", 8'h0C, 32'h5);
    rd_chk("R8 mask read at clear", 8'h10, 32'h5);
    wr(8'h10, 32'h1);
    rd_chk("R8 mask clear", 8'h0C, 32'h4);
    pulse_irq(4'b0100, 4'b0000);
    check("R8 masked vector silent", 32'(irq), 32'h0);
    pulse_irq(4'b0001, 4'b0000);
    check("R8 unmasked vector raises", 32'(irq), 32'h1);
    pulse_irq(4'b0000, 4'b0001);
    check("R8 pending clear drops", 32'(irq), 32'h0);
    pulse_irq(4'b0001, 4'b0000);
    check("R8 raise again", 32'(irq), 32'h1);
    wr(8'h14, 32'h0000_4000);
    check("R9 shutdown clears irq", 32'(irq), 32'h0);
    rd_chk("R9 shutdown clears mask", 8'h0C, 32'h0);
    pulse_irq(4'b0100, 4'b0000);
    check("R9 vector unmasked after clear", 32'(irq), 32'h1);
    wr(8'h14, 32'h1);
    check("R3 start on rise from shutdown word", 32'(start_req), 32'h1);
    wr(8'h0C, 32'h2);
    wr(8'h14, 32'h0);
    check("R9 reset clears irq", 32'(irq), 32'h0);
    rd_chk("R9 reset clears mask", 8'h0C, 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cc_mask();
    t_admin();
    t_start_ok();
    t_disable();
    t_start_fail();
    t_cancel();
    t_shutdown();
    t_combined();
    t_irq();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule